// File: doc/BRIEF.md
# NEC Infrared Frame Decoder

This block turns the output of an infrared receiver module into command bytes. The receiver has already removed the carrier, so its output is idle high and goes low for each burst. The block times each low and high stretch against a one-microsecond tick that it derives from the system clock. It first looks for the long start burst and the gap after it. It then reads 32 data bits, using the length of each gap to decide whether the bit is a 0 or a 1.

When all 32 bits are in, the block checks both byte pairs. If each pair is a byte followed by its complement, it presents the command byte and raises a strobe for one clock. A stretch that is too short, too long or missing drops the frame without any report, and the block waits for the next start burst. Repeat codes are not handled.

All timing windows are parameters given in microseconds. The defaults follow the protocol. A bench or an unusual system can scale the windows down.

Top module: `nec_rx_decoder`

## Requirements
- R1: During and after reset, `cmd` is 0x00 and `cmd_valid` is low.
- R2: A well-formed frame makes `cmd_valid` high for exactly one clock, with `cmd` equal to frame byte 2.
- R3: The start burst (line low) is accepted only if its length is between LEAD_LOW_MIN_US and LEAD_LOW_MAX_US inclusive (8000..10000 us by default). Any other length drops the frame.
- R4: A start burst that is still low after LEAD_LOW_LIMIT_US (12000 us) is dropped. The block then waits for a new falling edge, so the line rising later does not restart decoding.
- R5: The gap after the start burst (line high) is accepted only if it lasts 3500..5000 us inclusive. The frame is dropped if no falling edge arrives within 7000 us.
- R6: A data burst that stays low for longer than 1000 us drops the frame. Exactly 1000 us is accepted.
- R7: A data gap shorter than 200 us drops the frame, and so does a data gap longer than 2500 us. The values 200 us and 2500 us are accepted.
- R8: A data gap longer than 1200 us is a 1; a gap of 1200 us or less is a 0. Bit k of arrival (k = 0..31) lands in byte k/8 at bit position k mod 8. Byte 0 is first and each byte fills from its least significant bit.
- R9: A frame is released only if byte0 + byte1 = 0xFF and byte2 + byte3 = 0xFF, modulo 256. Otherwise there is no strobe and `cmd` keeps its previous value.
- R10: A frame that is cut short leaves no trace: the next complete frame decodes correctly, and `cmd` holds its value until that frame is released.
- R11: If the line stays high with no falling edge for more than IDLE_LIMIT_US (150 ms), the block rearms and still decodes the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_n | input | 1 | Raw receiver output, low while a burst is present |
| cmd | output | 8 | Last released command byte |
| cmd_valid | output | 1 | One-clock strobe when `cmd` is updated |

## Verification
A phase timeout and the edge that ends the same phase can happen in the same clock, when a burst or gap lasts exactly one microsecond past its limit. In that case the timeout must win and the frame must be dropped. When the length equals the limit, the edge must be accepted. The bench drives data bursts of exactly the limit and one microsecond over it, and data gaps of exactly the limit and one microsecond over it. It then judges the result by whether a strobe and the expected `cmd` appear.

// File: rtl/nec_pkg.sv
package nec_pkg;

  localparam int FRAME_BITS = 32;
  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = FRAME_BITS / BYTE_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LMARK,
    S_LSPACE,
    S_BMARK,
    S_BSPACE,
    S_CHECK
  } dec_state_e;

  // A byte pair is valid when the two bytes sum to all-ones (mod 256).
  function automatic logic pair_is_complement(input logic [BYTE_W-1:0] a,
                                              input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] s;
    s = a + b;
    return s == {BYTE_W{1'b1}};
  endfunction

  // Inclusive range test on a measured width.
  function automatic logic in_window(input logic [31:0] w,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (w >= lo) && (w <= hi);
  endfunction

endpackage

// File: rtl/nec_sync.sv
module nec_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
endmodule

// File: rtl/nec_us_timer.sv
module nec_us_timer #(
  parameter int DIV   = 50,
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] width
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0]    pre;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             sat;

  assign tick = (pre == PW'(DIV - 1));
  assign sat  = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (restart) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick && !sat) cnt <= cnt + 1'b1;
    end
  end

  // Width including the tick of the current cycle: an edge spaced N us
  // after the previous one reads exactly N.
  assign width = cnt + CNT_W'(tick && !sat);
endmodule

// File: rtl/nec_frame.sv
module nec_frame
  import nec_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          push,
  input  logic                          bit_in,
  output logic [FRAME_BITS-1:0]         word,
  output logic [$clog2(FRAME_BITS+1)-1:0] bit_cnt,
  output logic [BYTE_W-1:0]             cmd_byte,
  output logic                          pairs_ok
);
  logic [BYTE_W-1:0] byte_v [NUM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (clr) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (push) begin
      word    <= {bit_in, word[FRAME_BITS-1:1]};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_bytes
    assign byte_v[g] = word[g*BYTE_W +: BYTE_W];
  end

  assign cmd_byte = byte_v[2];
  assign pairs_ok = pair_is_complement(byte_v[0], byte_v[1]) &&
                    pair_is_complement(byte_v[2], byte_v[3]);
endmodule

// File: rtl/nec_rx_decoder.sv
module nec_rx_decoder
  import nec_pkg::*;
#(
  parameter int CLK_HZ             = 50_000_000,
  parameter int IDLE_LIMIT_US      = 150_000,
  parameter int LEAD_LOW_MIN_US    = 8000,
  parameter int LEAD_LOW_MAX_US    = 10_000,
  parameter int LEAD_LOW_LIMIT_US  = 12_000,
  parameter int LEAD_HIGH_MIN_US   = 3500,
  parameter int LEAD_HIGH_MAX_US   = 5000,
  parameter int LEAD_HIGH_LIMIT_US = 7000,
  parameter int BIT_LOW_LIMIT_US   = 1000,
  parameter int BIT_HIGH_MIN_US    = 200,
  parameter int BIT_ONE_ABOVE_US   = 1200,
  parameter int BIT_HIGH_LIMIT_US  = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_n,
  output logic [7:0] cmd,
  output logic       cmd_valid
);
  localparam int DIV   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int CNT_W = $clog2(IDLE_LIMIT_US + LEAD_LOW_LIMIT_US + 2);
  localparam int BC_W  = $clog2(FRAME_BITS + 1);

  // Named internal events (also observed by the checker).
  logic                  line, rise, fall;
  logic [CNT_W-1:0]      width;
  logic [31:0]           wu;
  logic                  restart;
  dec_state_e            state, state_nx;
  logic                  frame_clr, bit_push, bit_val;
  logic [FRAME_BITS-1:0] word;
  logic [BC_W-1:0]       bit_cnt;
  logic [BYTE_W-1:0]     cmd_byte;
  logic                  pairs_ok;
  logic                  idle_expired;

  nec_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (ir_n),
    .level(line),
    .rise (rise),
    .fall (fall)
  );

  nec_us_timer #(.DIV(DIV), .CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .width  (width)
  );

  nec_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (frame_clr),
    .push    (bit_push),
    .bit_in  (bit_val),
    .word    (word),
    .bit_cnt (bit_cnt),
    .cmd_byte(cmd_byte),
    .pairs_ok(pairs_ok)
  );

  assign wu           = 32'(width);
  assign idle_expired = (state == S_IDLE) && (wu > 32'(IDLE_LIMIT_US));
  assign restart      = rise | fall | idle_expired;
  assign bit_val      = wu > 32'(BIT_ONE_ABOVE_US);

  always_comb begin
    state_nx  = state;
    frame_clr = 1'b0;
    bit_push  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (fall) begin
          state_nx  = S_LMARK;
          frame_clr = 1'b1;
        end
      end
      S_LMARK: begin
        if (wu > 32'(LEAD_LOW_LIMIT_US)) state_nx = S_IDLE;
        else if (rise)
          state_nx = in_window(wu, LEAD_LOW_MIN_US, LEAD_LOW_MAX_US) ? S_LSPACE : S_IDLE;
      end
      S_LSPACE: begin
        if (wu > 32'(LEAD_HIGH_LIMIT_US)) state_nx = S_IDLE;
        else if (fall)
          state_nx = in_window(wu, LEAD_HIGH_MIN_US, LEAD_HIGH_MAX_US) ? S_BMARK : S_IDLE;
      end
      S_BMARK: begin
        if (wu > 32'(BIT_LOW_LIMIT_US)) state_nx = S_IDLE;
        else if (rise)                  state_nx = S_BSPACE;
      end
      S_BSPACE: begin
        if (wu > 32'(BIT_HIGH_LIMIT_US)) state_nx = S_IDLE;
        else if (fall) begin
          if (wu < 32'(BIT_HIGH_MIN_US)) state_nx = S_IDLE;
          else begin
            bit_push = 1'b1;
            state_nx = (bit_cnt == BC_W'(FRAME_BITS - 1)) ? S_CHECK : S_BMARK;
          end
        end
      end
      S_CHECK: state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cmd       <= '0;
      cmd_valid <= 1'b0;
    end else begin
      state     <= state_nx;
      cmd_valid <= 1'b0;
      if (state == S_CHECK && pairs_ok) begin
        cmd       <= cmd_byte;
        cmd_valid <= 1'b1;
      end
    end
  end

  // line level kept as a named event for debug; unused by the FSM
  logic line_unused;
  assign line_unused = line;
endmodule

// File: rtl/nec_rx_decoder_chk.sv
module nec_rx_decoder_chk
  import nec_pkg::*;
#(
  parameter int LM_MIN = 8000,
  parameter int LM_MAX = 10_000,
  parameter int BM_TO  = 1000,
  parameter int BC_W   = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input dec_state_e            state,
  input logic [31:0]           wu,
  input logic [BC_W-1:0]       bit_cnt,
  input logic [FRAME_BITS-1:0] word,
  input logic [7:0]            cmd,
  input logic                  cmd_valid
);
  a_r2_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r9_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd));

  a_r9_pairs_checked: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (((word[7:0] ^ word[15:8]) == 8'hFF) &&
                   ((word[23:16] ^ word[31:24]) == 8'hFF) &&
                   (cmd == word[23:16])));

  a_r3_lead_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LSPACE && $past(state) == S_LMARK) |->
      ($past(wu) >= 32'(LM_MIN) && $past(wu) <= 32'(LM_MAX)));

  a_r6_bit_low_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BMARK && wu > 32'(BM_TO)) |=> (state == S_IDLE));

  a_r8_bit_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BC_W'(FRAME_BITS));
endmodule

bind nec_rx_decoder nec_rx_decoder_chk #(
  .LM_MIN(LEAD_LOW_MIN_US),
  .LM_MAX(LEAD_LOW_MAX_US),
  .BM_TO (BIT_LOW_LIMIT_US),
  .BC_W  (BC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state),
  .wu       (wu),
  .bit_cnt  (bit_cnt),
  .word     (word),
  .cmd      (cmd),
  .cmd_valid(cmd_valid)
);

// File: tb/nec_rx_decoder_tb.sv
`timescale 1ns/1ps
module nec_rx_decoder_tb;
  // Windows scaled by 1/50, 2 clocks per microsecond.
  localparam int US = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_n = 1'b1;
  logic [7:0] cmd;
  logic       cmd_valid;

  int checks = 0;
  int errors = 0;
  int hi_cnt = 0;
  int pulse_cnt = 0;
  logic v_prev = 1'b0;
  logic [7:0] exp_cmd = 8'h00;

  always #5 clk = ~clk;

  nec_rx_decoder #(
    .CLK_HZ(2_000_000), .IDLE_LIMIT_US(3000),
    .LEAD_LOW_MIN_US(160), .LEAD_LOW_MAX_US(200), .LEAD_LOW_LIMIT_US(240),
    .LEAD_HIGH_MIN_US(70), .LEAD_HIGH_MAX_US(100), .LEAD_HIGH_LIMIT_US(140),
    .BIT_LOW_LIMIT_US(20), .BIT_HIGH_MIN_US(4), .BIT_ONE_ABOVE_US(24),
    .BIT_HIGH_LIMIT_US(50)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ir_n(ir_n), .cmd(cmd), .cmd_valid(cmd_valid)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) hi_cnt++;
      if (cmd_valid && !v_prev) pulse_cnt++;
      v_prev = cmd_valid;
    end
  end

  typedef struct packed {
    logic [9:0]  lm;
    logic [9:0]  ls;
    logic [7:0]  bm;
    logic [7:0]  s0;
    logic [7:0]  s1;
    logic [31:0] word;
    logic        tok;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{10'd180, 10'd90,  8'd11, 8'd11, 8'd34, 32'hBA45FF00, 1'b1},  // R2 nominal
    '{10'd160, 10'd70,  8'd11, 8'd11, 8'd34, 32'h58A7ED12, 1'b1},  // R3 R5 low edges
    '{10'd200, 10'd100, 8'd11, 8'd11, 8'd34, 32'hFF0000FF, 1'b1},  // R3 R5 high edges
    '{10'd159, 10'd90,  8'd11, 8'd11, 8'd34, 32'hBA45FF00, 1'b0},  // R3 short
    '{10'd201, 10'd90,  8'd11, 8'd11, 8'd34, 32'hBA45FF00, 1'b0},  // R3 long
    '{10'd180, 10'd69,  8'd11, 8'd11, 8'd34, 32'hBA45FF00, 1'b0},  // R5 short
    '{10'd180, 10'd101, 8'd11, 8'd11, 8'd34, 32'hBA45FF00, 1'b0},  // R5 long
    '{10'd180, 10'd90,  8'd20, 8'd11, 8'd34, 32'hC33CA55A, 1'b1},  // R6 at limit
    '{10'd180, 10'd90,  8'd21, 8'd11, 8'd34, 32'hC33CA55A, 1'b0},  // R6 over
    '{10'd180, 10'd90,  8'd11, 8'd4,  8'd25, 32'h817E7E81, 1'b1},  // R7 R8 edges
    '{10'd180, 10'd90,  8'd11, 8'd3,  8'd34, 32'hBA45FF00, 1'b0},  // R7 too short
    '{10'd180, 10'd90,  8'd11, 8'd24, 8'd50, 32'h69963CC3, 1'b1},  // R7 R8 edges
    '{10'd180, 10'd90,  8'd11, 8'd11, 8'd51, 32'hBA45FF00, 1'b0},  // R7 too long
    '{10'd180, 10'd90,  8'd11, 8'd11, 8'd34, 32'hBA45FE00, 1'b1},  // R9 addr pair
    '{10'd180, 10'd90,  8'd11, 8'd11, 8'd34, 32'hBB45FF00, 1'b1},  // R9 cmd pair
    '{10'd180, 10'd90,  8'd11, 8'd11, 8'd34, 32'h1EE15AA5, 1'b1}   // R8 mixed
  };

  function automatic logic frame_ok(input logic [31:0] w);
    return ((w[7:0] ^ w[15:8]) == 8'hFF) && ((w[23:16] ^ w[31:24]) == 8'hFF);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lvl, input int us);
    ir_n = lvl;
    repeat (us * US) @(negedge clk);
  endtask

  task automatic send(input int lm, input int ls, input int bm, input int s0,
                      input int s1, input logic [31:0] w, input int nbits);
    drive(1'b0, lm);
    drive(1'b1, ls);
    for (int i = 0; i < nbits; i++) begin
      drive(1'b0, bm);
      drive(1'b1, w[i] ? s1 : s0);
    end
    if (nbits == 32) drive(1'b0, 11);
    drive(1'b1, 300);
  endtask

  task automatic expect_result(input logic ok, input logic [31:0] w, input string req,
                               input int p0, input int h0);
    int n;
    n = ok ? 1 : 0;
    if (ok) exp_cmd = w[23:16];
    check(pulse_cnt - p0 == n, req, pulse_cnt - p0, n);
    check(hi_cnt - h0 == n, {req, " R2 width"}, hi_cnt - h0, n);
    check(cmd == exp_cmd, {req, " cmd"}, cmd, exp_cmd);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0, h0;
    repeat (5) @(negedge clk);
    check(cmd == 8'h00, "R1 cmd in reset", cmd, 0);
    check(cmd_valid == 1'b0, "R1 valid in reset", cmd_valid, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(cmd == 8'h00 && !cmd_valid, "R1 after reset", cmd, 0);

    foreach (VECS[k]) begin
      p0 = pulse_cnt; h0 = hi_cnt;
      send(VECS[k].lm, VECS[k].ls, VECS[k].bm, VECS[k].s0, VECS[k].s1, VECS[k].word, 32);
      expect_result(VECS[k].tok && frame_ok(VECS[k].word), VECS[k].word,
                    $sformatf("R2/R9 vector %0d", k), p0, h0);
    end

    // R4: start burst held past its limit, then released; no frame from it.
    p0 = pulse_cnt; h0 = hi_cnt;
    drive(1'b0, 300);
    drive(1'b1, 90);
    for (int i = 0; i < 32; i++) begin
      drive(1'b0, 11);
      drive(1'b1, 34);
    end
    drive(1'b0, 11);
    drive(1'b1, 300);
    expect_result(1'b0, 32'h0, "R4 stuck low", p0, h0);
    p0 = pulse_cnt; h0 = hi_cnt;
    send(180, 90, 11, 11, 34, 32'h33CCCC33, 32);
    expect_result(1'b1, 32'h33CCCC33, "R4 rearm", p0, h0);

    // R10: partial frame then a good one.
    p0 = pulse_cnt; h0 = hi_cnt;
    send(180, 90, 11, 11, 34, 32'hFFFFFFFF, 10);
    expect_result(1'b0, 32'h0, "R10 partial", p0, h0);
    p0 = pulse_cnt; h0 = hi_cnt;
    send(180, 90, 11, 11, 34, 32'h7F80FE01, 32);
    expect_result(1'b1, 32'h7F80FE01, "R10 after partial", p0, h0);

    // R11: long idle beyond the idle limit, then a frame.
    drive(1'b1, 3500);
    p0 = pulse_cnt; h0 = hi_cnt;
    send(180, 90, 11, 11, 34, 32'hEE11BB44, 32);
    expect_result(1'b1, 32'hEE11BB44, "R11 after idle", p0, h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule